// File: doc/BRIEF.md
# One-Shot Sinc Decimator for Incremental Conversion

This block is the digital back end of an incremental converter. It takes the single-bit stream of a modulator and runs it through a cascade of ORDER integrators and ORDER comb sections, with the combs clocked once per RATIO accepted samples. It does not stream results. A start strobe clears every register. The filter then takes exactly ORDER·RATIO accepted samples and delivers one result word with a one-cycle done flag. The block then sits idle until the next start.

ORDER is normally set one above the modulator order. RATIO is picked so that the sample rate divided by RATIO lands on the mains frequency. The response then has a notch there and at every multiple of it. All arithmetic wraps in two's complement at ORDER·log2(RATIO)+1 bits, and the result word is read modulo that width.

Top module: `sinc_oneshot_dec`

## Requirements
- R1: After reset, result_o is zero and done_o is low.
- R2: Each accepted bit counts as +1 when high and −1 when low. The result equals the sum of these values, each weighted by the sinc^ORDER impulse response (ORDER-fold self-convolution of a length-RATIO box of ones), with the newest sample weighted by tap 0. The sum is taken modulo 2^W and read as W-bit two's complement.
- R3: done_o is high for exactly one cycle, in the cycle after the ORDER·RATIO-th accepted sample. result_o takes its new value in that same cycle and holds it until the next conversion completes.
- R4: A start pulse clears all integrator and comb state and restarts the count, also in the middle of a conversion. The next result depends only on samples accepted after that start.
- R5: Cycles with valid_i low during a conversion have no effect on state. Gaps between samples do not change the result.
- R6: While no conversion is running, valid_i and bit_i are ignored. done_o stays low and result_o stays unchanged.
- R7: In a cycle where start_i is high, a simultaneous valid_i sample is discarded.
- R8: With full-scale input (all high or all low) the exact sum is ±RATIO^ORDER. Both cases read as the pattern with only bit W−1 set (0x1000 at the defaults).
- R9: The first ORDER−1 samples of a conversion carry zero weight.
- R10: An input that repeats every RATIO samples with equal numbers of highs and lows in each period gives a result of exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the filter and begins a conversion |
| valid_i | input | 1 | bit_i carries a modulator sample this cycle |
| bit_i | input | 1 | Modulator output bit |
| result_o | output | ORDER·log2(RATIO)+1 | Filtered conversion result, two's complement, wrapped |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The hardest case to reach from the ports is the wrap at full scale. There the exact sum lands one past the largest positive word, so the +1 and −1 runs must both fold onto the same pattern. The bench reaches it with directed all-high and all-low conversions. The zero-weight leading samples and the mains notch sit just as deep inside the arithmetic. They are reached with paired conversions that differ only in their first ORDER−1 bits, and with a half-high, half-low pattern of period RATIO. Random streams with random idle gaps, an aborted conversion and a start coinciding with a valid sample cover the sequencing.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} conv_state_e;
endpackage

// File: rtl/sinc_integrators.sv
module sinc_integrators #(
  parameter int ORDER = 3,
  parameter int W     = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] sum_o
);
  logic [ORDER-1:0][W-1:0] acc_q, acc_d;
  logic [W-1:0] x;

  assign x = bit_i ? W'(1) : {W{1'b1}};

  // next values chained so the last stage already includes the current sample
  always_comb begin
    acc_d[0] = acc_q[0] + x;
    for (int s = 1; s < ORDER; s++) acc_d[s] = acc_q[s] + acc_d[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_d;
  end

  assign sum_o = acc_d[ORDER-1];

  p_clear_integ_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
  p_hold_integ_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/sinc_combs.sv
module sinc_combs #(
  parameter int ORDER = 3,
  parameter int W     = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic [ORDER-1:0][W-1:0] dly_q;
  logic [ORDER:0][W-1:0]   stg;

  always_comb begin
    stg[0] = din_i;
    for (int s = 0; s < ORDER; s++) stg[s+1] = stg[s] - dly_q[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dly_q <= '0;
    else if (clr_i) dly_q <= '0;
    else if (en_i)  dly_q <= stg[ORDER-1:0];
  end

  assign dout_o = stg[ORDER];

  p_clear_comb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (dly_q == '0));
  p_hold_comb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(dly_q));
endmodule

// File: rtl/sinc_sequencer.sv
module sinc_sequencer
  import sinc_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int RATIO = 16,
  localparam int LOGN = $clog2(RATIO),
  localparam int BW   = $clog2(ORDER + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic valid_i,
  output logic clr_o,
  output logic smp_o,
  output logic dec_o,
  output logic last_o,
  output logic busy_o
);
  conv_state_e state_q;
  logic [LOGN-1:0] phase_q;
  logic [BW-1:0]   blk_q;

  assign clr_o  = start_i;
  assign busy_o = (state_q == ST_RUN);
  assign smp_o  = valid_i && busy_o && !start_i;
  assign dec_o  = smp_o && (phase_q == LOGN'(RATIO - 1));
  assign last_o = dec_o && (blk_q == BW'(ORDER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      blk_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_RUN;
      phase_q <= '0;
      blk_q   <= '0;
    end else if (smp_o) begin
      phase_q <= phase_q + LOGN'(1);
      if (dec_o)  blk_q   <= blk_q + BW'(1);
      if (last_o) state_q <= ST_IDLE;
    end
  end

  p_start_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_RUN && phase_q == '0 && blk_q == '0));
  p_last_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sinc_oneshot_dec.sv
module sinc_oneshot_dec #(
  parameter int ORDER = 3,
  parameter int RATIO = 16,
  localparam int LOGN = $clog2(RATIO),
  localparam int W    = ORDER * LOGN + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         valid_i,
  input  logic         bit_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  logic clr, smp, dec, last, busy;
  logic [W-1:0] integ_sum, comb_out;

  sinc_sequencer #(.ORDER(ORDER), .RATIO(RATIO)) u_seq (
    .clk_i, .rst_ni, .start_i, .valid_i,
    .clr_o(clr), .smp_o(smp), .dec_o(dec), .last_o(last), .busy_o(busy)
  );

  sinc_integrators #(.ORDER(ORDER), .W(W)) u_integ (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(smp), .bit_i, .sum_o(integ_sum)
  );

  sinc_combs #(.ORDER(ORDER), .W(W)) u_comb (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(dec), .din_i(integ_sum), .dout_o(comb_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last;
      if (last) result_o <= comb_out;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_result_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
  p_idle_no_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> !done_o);
endmodule

// File: tb/sinc_oneshot_dec_tb.sv
`timescale 1ns/1ps
module sinc_oneshot_dec_tb;
  localparam int L  = 3;
  localparam int N  = 16;
  localparam int W  = L * $clog2(N) + 1;
  localparam int M  = L * N;
  localparam int WD = 20000;

  logic clk_i = 1'b0;
  logic rst_ni, start_i, valid_i, bit_i;
  logic [W-1:0] result_o;
  logic done_o;
  int checks = 0, failures = 0, cyc = 0, early_done = 0;

  always #2.5 clk_i = ~clk_i;

  sinc_oneshot_dec #(.ORDER(L), .RATIO(N)) u_dut (
    .clk_i, .rst_ni, .start_i, .valid_i, .bit_i, .result_o, .done_o
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WD) begin
      failures++;
      $display("FAIL R3 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [W-1:0] model(input logic [M-1:0] b);
    int h [M];
    int t [M];
    int acc;
    for (int i = 0; i < M; i++) h[i] = (i < N) ? 1 : 0;
    for (int s = 1; s < L; s++) begin
      for (int i = 0; i < M; i++) begin
        t[i] = 0;
        for (int j = 0; j < N; j++) if (i - j >= 0) t[i] += h[i-j];
      end
      h = t;
    end
    acc = 0;
    for (int k = 0; k < M; k++) acc += h[M-1-k] * (b[k] ? 1 : -1);
    return acc[W-1:0];
  endfunction

  task automatic check_eq(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [M-1:0] b, input bit gaps, input bit start_valid,
                          output logic [W-1:0] res);
    @(negedge clk_i);
    start_i = 1'b1; valid_i = start_valid; bit_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < M; k++) begin
      if (gaps) begin
        int g;
        g = $urandom_range(2);
        for (int i = 0; i < g; i++) begin
          valid_i = 1'b0; bit_i = 1'($urandom_range(1));
          @(negedge clk_i);
          if (done_o) early_done++;
        end
      end
      if (done_o) early_done++;
      valid_i = 1'b1; bit_i = b[k];
      @(negedge clk_i);
    end
    valid_i = 1'b0;
    check_eq("R3 done after last sample", W'(done_o), W'(1));
    res = result_o;
    @(negedge clk_i);
    check_eq("R3 done one cycle", W'(done_o), W'(0));
    check_eq("R3 result held", result_o, res);
  endtask

  initial begin
    logic [M-1:0] v, v2;
    logic [W-1:0] r, r2, hold;
    void'($urandom(32'd7));
    rst_ni = 1'b0; start_i = 1'b0; valid_i = 1'b0; bit_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check_eq("R1 reset result", result_o, '0);
    check_eq("R1 reset done", W'(done_o), W'(0));
    rst_ni = 1'b1;

    // R6: samples before any start are ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i); valid_i = 1'b1; bit_i = 1'($urandom_range(1));
    end
    @(negedge clk_i); valid_i = 1'b0;
    check_eq("R6 idle done", W'(done_o), W'(0));
    check_eq("R6 idle result", result_o, '0);

    // R8: full-scale wrap
    run_conv({M{1'b1}}, 1'b0, 1'b0, r);
    check_eq("R8 all high", r, W'(1) << (W - 1));
    check_eq("R2 all high model", r, model({M{1'b1}}));
    run_conv({M{1'b0}}, 1'b0, 1'b0, r);
    check_eq("R8 all low", r, W'(1) << (W - 1));

    // R10: zero-mean period-N pattern lands in the notch
    for (int k = 0; k < M; k++) v[k] = ((k % N) < N / 2);
    run_conv(v, 1'b1, 1'b0, r);
    check_eq("R10 notch", r, '0);

    // R9: first L-1 samples do not matter
    v  = M'({$urandom(), $urandom()});
    v2 = v ^ M'((1 << (L - 1)) - 1);
    run_conv(v, 1'b0, 1'b0, r);
    run_conv(v2, 1'b1, 1'b0, r2);
    check_eq("R9 leading samples", r2, r);
    check_eq("R2 model", r, model(v));

    // R2 / R5: random streams with idle gaps
    for (int n = 0; n < 8; n++) begin
      v = M'({$urandom(), $urandom()});
      run_conv(v, 1'b1, 1'b0, r);
      check_eq("R5 R2 random gaps", r, model(v));
    end

    // R6: valid after completion ignored
    hold = result_o;
    for (int i = 0; i < 12; i++) begin
      valid_i = 1'b1; bit_i = 1'($urandom_range(1));
      @(negedge clk_i);
      if (done_o) early_done++;
    end
    valid_i = 1'b0;
    check_eq("R6 result after idle samples", result_o, hold);

    // R4: abort a running conversion
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      valid_i = 1'b1; bit_i = 1'b1; @(negedge clk_i);
    end
    valid_i = 1'b0;
    v = M'({$urandom(), $urandom()});
    run_conv(v, 1'b1, 1'b0, r);
    check_eq("R4 restart", r, model(v));

    // R7: sample coinciding with start is dropped
    v = M'({$urandom(), $urandom()});
    run_conv(v, 1'b0, 1'b1, r);
    check_eq("R7 start priority", r, model(v));

    check_eq("R3 R6 no stray done", W'(early_done), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule